// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus that runs in 16-bit word mode. It turns one request into the chain of bus write cycles that starts a word program, a sector erase or a whole-chip erase. A request carries an operation code, a word address and a data word. Once the block accepts a request, it holds chip enable low for the whole command and drives each write cycle itself. Every cycle has one address/data setup cycle, a write-enable low pulse and a write-enable high recovery period. All lengths are counted in system clock cycles, derived from nanosecond minimums and rounded up.

The first cycles of each command are the fixed unlock pairs. They come from a small internal table. The final two cycles depend on the operation. When the last recovery period has elapsed, the block releases the bus and gives a one-cycle completion strobe. Status polling belongs to a separate block, which takes over at that point. Output enable is held high all the time, because this block never reads the array.

The state machine has five states:
- `ST_IDLE`: the bus is released and the request input is ready.
- `ST_SETUP`: address and data are driven with write enable high.
- `ST_PULSE`: write enable is low.
- `ST_RECOV`: write enable is high and address and data are held.
- `ST_DONE`: the bus is released and the completion strobe is high.

The transitions are:
- `ST_IDLE`→`ST_SETUP` on an accepted request.
- `ST_SETUP`→`ST_PULSE` after one cycle.
- `ST_PULSE`→`ST_RECOV` when the pulse count expires.
- `ST_RECOV`→`ST_SETUP` when the recovery count expires and steps remain.
- `ST_RECOV`→`ST_DONE` when it expires on the final step.
- `ST_DONE`→`ST_IDLE` after one cycle.

Top module: `nor_cmd_seq`

## Requirements
- R1: During and after reset, with no request pending: `flash_ce_n`, `flash_oe_n` and `flash_we_n` are high, `flash_dq_oe` is low, `req_ready` is high and `done` is low.
- R2: Request acceptance and ready:
  - A request is accepted on a clock edge where `req_valid` and `req_ready` are both high and `req_op` is 0 (program), 1 (sector erase) or 2 (chip erase).
  - `req_op` = 3 is never accepted, and the bus stays idle.
  - `req_ready` is low from the cycle after acceptance through the completion cycle.
- R3: A program command drives four write cycles, written as (address, data) in hex: (555, 00AA), (2AA, 0055), (555, 00A0), then (request address, request data).
- R4: A sector erase drives six write cycles: (555, 00AA), (2AA, 0055), (555, 0080), (555, 00AA), (2AA, 0055), then (request address, 0030).
- R5: A chip erase drives the same first five write cycles as R4, then (555, 0010). The request address and data are not used.
- R6: Each write cycle runs as follows:
  - One setup cycle with `flash_we_n` high and the address and data driven.
  - `flash_we_n` low for WP_CYC cycles.
  - `flash_we_n` high for HI_CYC cycles.
  - The address and data do not change from the setup cycle through the end of the high period.
- R7: WP_CYC = max(ceil(T_WP/T_CLK), ceil(T_DS/T_CLK) − 1, 1).
- R8: HI_CYC = max(ceil(T_WPH/T_CLK), ceil(T_WC/T_CLK) − 1 − WP_CYC, ceil(T_AH/T_CLK) − WP_CYC, 1). This keeps the full cycle at or above T_WC, the address hold from the falling edge at or above T_AH, and the high time before the next falling edge at or above T_WPH.
- R9: Chip enable and data drive during a command:
  - `flash_ce_n` is low and `flash_dq_oe` is high from the first setup cycle through the last high period, with no gap between write cycles.
  - Outside a command both are inactive.
  - `flash_oe_n` is always high.
- R10: After the last high period, `done` is high for exactly one cycle. In that cycle chip enable is high and `req_ready` is low. `req_ready` returns high in the following cycle.
- R11: Changes on `req_valid`, `req_op`, `req_addr` and `req_data` while a command is in progress have no effect on the bus sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| req_addr | input | ADDR_W | Program address or sector address (word units) |
| req_data | input | DATA_W | Program data word |
| done | output | 1 | One-cycle strobe after the final write cycle |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low (held high) |
| flash_we_n | output | 1 | Write enable, active low |
| flash_addr | output | ADDR_W | Flash word address |
| flash_dq_out | output | DATA_W | Data driven onto the flash data lines |
| flash_dq_oe | output | 1 | Drive enable for the flash data lines |

## Verification
A wrong state or step index shows at the ports within one clock:
- A skipped or repeated step shows as a wrong address/data pair in the next setup cycle.
- A miscounted timer shows as a write-enable edge one cycle early or late.

Because the reference model compares every output on every clock, a defect is caught in the first cycle where it changes the bus. It is not deferred to the completion strobe. Requests made while a command runs, and the reserved operation code, are checked by watching the bus for the whole sequence to make sure it is unaffected.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_RECOV,
        ST_DONE
    } state_e;

    localparam logic [11:0] ADR_UNLK1 = 12'h555;
    localparam logic [11:0] ADR_UNLK2 = 12'h2AA;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // nanoseconds to whole clock cycles, rounded up
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    // difference clamped at zero
    function automatic int unsigned sub0(input int unsigned a, input int unsigned b);
        return (a > b) ? a - b : 0;
    endfunction

    // number of bus write cycles for an operation
    function automatic logic [2:0] steps_of(input op_e op);
        return (op == OP_PROG) ? 3'd4 : 3'd6;
    endfunction

endpackage

// File: rtl/nor_seq_timer.sv
module nor_seq_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/nor_seq_cmd.sv
module nor_seq_cmd
    import nor_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned DATA_W = 16
) (
    input  op_e               op,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data
);
    localparam int unsigned PRE_N = 4;

    typedef struct packed {
        logic [11:0] adr;
        logic [7:0]  dat;
    } pair_t;

    // unlock prefix shared by all commands; program uses the first two entries
    pair_t prefix [PRE_N];
    assign prefix[0] = '{adr: ADR_UNLK1, dat: 8'hAA};
    assign prefix[1] = '{adr: ADR_UNLK2, dat: 8'h55};
    assign prefix[2] = '{adr: ADR_UNLK1, dat: 8'h80};
    assign prefix[3] = '{adr: ADR_UNLK1, dat: 8'hAA};

    logic [2:0] n_pre;
    assign n_pre = steps_of(op) - 3'd2;

    always_comb begin
        bus_addr = '0;
        bus_data = '0;
        if (step < n_pre) begin
            bus_addr = ADDR_W'(prefix[step[1:0]].adr);
            bus_data = DATA_W'(prefix[step[1:0]].dat);
        end else if (step == n_pre) begin
            if (op == OP_PROG) begin
                bus_addr = ADDR_W'(ADR_UNLK1);
                bus_data = DATA_W'(8'hA0);
            end else begin
                bus_addr = ADDR_W'(ADR_UNLK2);
                bus_data = DATA_W'(8'h55);
            end
        end else begin
            unique case (op)
                OP_PROG: begin
                    bus_addr = req_addr;
                    bus_data = req_data;
                end
                OP_SECT: begin
                    bus_addr = req_addr;
                    bus_data = DATA_W'(8'h30);
                end
                default: begin
                    bus_addr = ADDR_W'(ADR_UNLK1);
                    bus_data = DATA_W'(8'h10);
                end
            endcase
        end
    end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 21,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned CLK_NS  = 8,
    parameter int unsigned TWC_NS  = 70,
    parameter int unsigned TWP_NS  = 35,
    parameter int unsigned TWPH_NS = 30,
    parameter int unsigned TAH_NS  = 45,
    parameter int unsigned TDS_NS  = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              done,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic              flash_we_n,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [DATA_W-1:0] flash_dq_out,
    output logic              flash_dq_oe
);
    localparam int unsigned WP_CYC = imax(imax(ns2cyc(TWP_NS, CLK_NS),
                                               sub0(ns2cyc(TDS_NS, CLK_NS), 1)), 1);
    localparam int unsigned HI_CYC = imax(imax(ns2cyc(TWPH_NS, CLK_NS),
                                               sub0(ns2cyc(TWC_NS, CLK_NS), 1 + WP_CYC)),
                                          imax(sub0(ns2cyc(TAH_NS, CLK_NS), WP_CYC), 1));
    localparam int unsigned CNT_W  = $clog2(imax(WP_CYC, HI_CYC) + 1);

    state_e            state_q, state_nx;
    logic [2:0]        idx_q, idx_nx;
    op_e               op_q, op_nx;
    logic [ADDR_W-1:0] addr_q, addr_nx;
    logic [DATA_W-1:0] data_q, data_nx;
    logic              tm_load, tm_zero;
    logic [CNT_W-1:0]  tm_val;
    logic              last_step;
    logic [ADDR_W-1:0] tbl_addr;
    logic [DATA_W-1:0] tbl_data;

    nor_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .zero     (tm_zero)
    );

    nor_seq_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
        .op       (op_nx),
        .step     (idx_nx),
        .req_addr (addr_nx),
        .req_data (data_nx),
        .bus_addr (tbl_addr),
        .bus_data (tbl_data)
    );

    assign last_step = (idx_q == steps_of(op_q) - 3'd1);

    // next-state and capture logic
    always_comb begin
        state_nx = state_q;
        idx_nx   = idx_q;
        op_nx    = op_q;
        addr_nx  = addr_q;
        data_nx  = data_q;
        tm_load  = 1'b0;
        tm_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && (req_op != OP_NONE)) begin
                    state_nx = ST_SETUP;
                    idx_nx   = '0;
                    op_nx    = op_e'(req_op);
                    addr_nx  = req_addr;
                    data_nx  = req_data;
                end
            end
            ST_SETUP: begin
                state_nx = ST_PULSE;
                tm_load  = 1'b1;
                tm_val   = CNT_W'(WP_CYC - 1);
            end
            ST_PULSE: begin
                if (tm_zero) begin
                    state_nx = ST_RECOV;
                    tm_load  = 1'b1;
                    tm_val   = CNT_W'(HI_CYC - 1);
                end
            end
            ST_RECOV: begin
                if (tm_zero) begin
                    if (last_step) begin
                        state_nx = ST_DONE;
                    end else begin
                        state_nx = ST_SETUP;
                        idx_nx   = idx_q + 3'd1;
                    end
                end
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            op_q    <= OP_PROG;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_nx;
            idx_q   <= idx_nx;
            op_q    <= op_nx;
            addr_q  <= addr_nx;
            data_q  <= data_nx;
        end
    end

    // registered bus outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flash_ce_n   <= 1'b1;
            flash_we_n   <= 1'b1;
            flash_dq_oe  <= 1'b0;
            flash_addr   <= '0;
            flash_dq_out <= '0;
            done         <= 1'b0;
        end else begin
            flash_ce_n   <= !(state_nx inside {ST_SETUP, ST_PULSE, ST_RECOV});
            flash_dq_oe  <=  (state_nx inside {ST_SETUP, ST_PULSE, ST_RECOV});
            flash_we_n   <=  (state_nx != ST_PULSE);
            flash_addr   <= tbl_addr;
            flash_dq_out <= tbl_data;
            done         <= (state_nx == ST_DONE);
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign flash_oe_n = 1'b1;

    // run-length counters for the write-enable checks
    logic [7:0] lowrun, highrun;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lowrun  <= '0;
            highrun <= 8'hFF;
        end else begin
            lowrun  <= flash_we_n ? 8'd0 : lowrun + 8'd1;
            highrun <= !flash_we_n ? 8'd0 : ((highrun == 8'hFF) ? highrun : highrun + 8'd1);
        end
    end

    // R7
    we_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> (lowrun == 8'(WP_CYC)));

    // R8
    we_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_we_n) |-> (highrun >= 8'(HI_CYC + 1)));

    // R6
    addr_during_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> ($stable(flash_addr) && $stable(flash_dq_out)));

    // R6
    hold_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |=> ($stable(flash_addr) && $stable(flash_dq_out)));

    // R9
    we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_ce_n |-> (flash_we_n && !flash_dq_oe));

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_ce_n |-> !req_ready);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flash_ce_n && !req_ready) ##1 (!done && req_ready));

endmodule

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb;
    localparam int AW = 21;
    localparam int DW = 16;
    localparam int PER = 8;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    function automatic int mx(input int a, input int b);
        return a > b ? a : b;
    endfunction

    // R7 / R8 from the nanosecond minimums
    localparam int WP = mx(mx(cdiv(35, PER), cdiv(35, PER) - 1), 1);
    localparam int HI = mx(mx(cdiv(30, PER), cdiv(70, PER) - 1 - WP), mx(cdiv(45, PER) - WP, 1));

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [1:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic          done;
    logic          flash_ce_n, flash_oe_n, flash_we_n, flash_dq_oe;
    logic [AW-1:0] flash_addr;
    logic [DW-1:0] flash_dq_out;

    always #(PER / 2) clk = ~clk;

    nor_cmd_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_op       (req_op),
        .req_addr     (req_addr),
        .req_data     (req_data),
        .done         (done),
        .flash_ce_n   (flash_ce_n),
        .flash_oe_n   (flash_oe_n),
        .flash_we_n   (flash_we_n),
        .flash_addr   (flash_addr),
        .flash_dq_out (flash_dq_out),
        .flash_dq_oe  (flash_dq_oe)
    );

    typedef struct {
        logic          ce_n;
        logic          we_n;
        logic          ready;
        logic          dn;
        logic [AW-1:0] adr;
        logic [DW-1:0] dat;
        string         tag;
    } frame_t;

    frame_t exp_q[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: sample mid-cycle and compare with the model
    task automatic step();
        frame_t e;
        @(negedge clk);
        if (exp_q.size() != 0) e = exp_q.pop_front();
        else e = '{ce_n: 1'b1, we_n: 1'b1, ready: 1'b1, dn: 1'b0, adr: '0, dat: '0, tag: "R1"};
        chk("R9",  "ce_n",  32'(flash_ce_n), 32'(e.ce_n));
        chk("R9",  "dq_oe", 32'(flash_dq_oe), 32'(!e.ce_n));
        chk("R9",  "oe_n",  32'(flash_oe_n), 32'd1);
        chk("R6",  "we_n",  32'(flash_we_n), 32'(e.we_n));
        chk("R2",  "ready", 32'(req_ready), 32'(e.ready));
        chk("R10", "done",  32'(done), 32'(e.dn));
        if (!e.ce_n) begin
            chk(e.tag, "addr", 32'(flash_addr), 32'(e.adr));
            chk(e.tag, "data", 32'(flash_dq_out), 32'(e.dat));
        end
    endtask

    task automatic push_cycle(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        frame_t f;
        f = '{ce_n: 1'b0, we_n: 1'b1, ready: 1'b0, dn: 1'b0, adr: a, dat: d, tag: tag};
        exp_q.push_back(f);
        f.we_n = 1'b0;
        for (int i = 0; i < WP; i++) exp_q.push_back(f);
        f.we_n = 1'b1;
        for (int i = 0; i < HI; i++) exp_q.push_back(f);
    endtask

    // R3, R4, R5 command tables
    task automatic push_seq(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        frame_t f;
        string tg;
        tg = (op == 2'd0) ? "R3" : (op == 2'd1) ? "R4" : "R5";
        push_cycle(21'h555, 16'h00AA, tg);
        push_cycle(21'h2AA, 16'h0055, tg);
        if (op == 2'd0) begin
            push_cycle(21'h555, 16'h00A0, tg);
            push_cycle(a, d, tg);
        end else begin
            push_cycle(21'h555, 16'h0080, tg);
            push_cycle(21'h555, 16'h00AA, tg);
            push_cycle(21'h2AA, 16'h0055, tg);
            if (op == 2'd1) push_cycle(a, 16'h0030, tg);
            else            push_cycle(21'h555, 16'h0010, tg);
        end
        f = '{ce_n: 1'b1, we_n: 1'b1, ready: 1'b0, dn: 1'b1, adr: '0, dat: '0, tag: "R10"};
        exp_q.push_back(f);
    endtask

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        while (!req_ready) step();
        req_op    = op;
        req_addr  = a;
        req_data  = d;
        req_valid = 1'b1;
        push_seq(op, a, d);
        step();
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) step();
        step();
    endtask

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_op    = 2'd0;
        req_addr  = '0;
        req_data  = '0;
        // R1 reset state
        repeat (3) step();
        rst_n = 1'b1;
        repeat (2) step();

        // R3 program
        issue(2'd0, 21'h1A5C3, 16'hBEEF);
        drain();

        // R4 sector erase
        issue(2'd1, 21'h1F0000, 16'h1234);
        drain();

        // R5 chip erase, address and data unused
        issue(2'd2, 21'h0ABCD, 16'hFFFF);
        drain();

        // R2 reserved code is not accepted
        req_op    = 2'd3;
        req_addr  = 21'h00777;
        req_valid = 1'b1;
        repeat (6) step();
        req_valid = 1'b0;
        step();

        // R11 inputs toggled while busy
        issue(2'd0, 21'h00100, 16'h5A5A);
        repeat (3) step();
        req_valid = 1'b1;
        req_op    = 2'd1;
        req_addr  = 21'h1FFFFF;
        req_data  = 16'h0000;
        repeat (5) step();
        req_op = 2'd2;
        repeat (5) step();
        req_valid = 1'b0;
        drain();

        // R10 back-to-back: next request as soon as ready returns
        issue(2'd1, 21'h008000, 16'h0);
        while (exp_q.size() != 0) step();
        issue(2'd0, 21'h1FFFFF, 16'h8001);
        drain();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule